// File: doc/BRIEF.md
# Stereo Audio Kernel Control Shell

This block wraps a per-frame stereo sample processor between a serial-audio front end and a host processor. Each frame delivers a left and a right signed PCM sample together with a one-cycle strobe. The results leave two cycles later with their own one-cycle strobe. Nothing is processed while the host has not yet signalled that it is ready. The first frame after the host becomes ready is spent on initialization and gives no output.

Once the block is running, each frame goes through one of three paths. The bypass switch copies the inputs to the outputs. The mute switch forces silence. Otherwise a gain stage scales each channel by an unsigned Q1.15 factor, truncates the product toward zero and clamps it to the sample range. The factor comes from a host-writable 32-bit control word, which holds a raw bit pattern. After reset the factor is one half.

The controller has four states:
- `ST_OFF`: the host is not ready.
- `ST_PRIME`: the block is waiting for the initialization frame.
- `ST_IDLE`: the block is waiting for a frame.
- `ST_BUSY`: the block is producing the result of a captured frame.

The transitions are:
- OFF→PRIME when ready is seen high without a strobe.
- OFF→IDLE when ready and a strobe arrive together. That strobe is the initialization frame.
- PRIME→IDLE on a strobe. That strobe is the initialization frame.
- IDLE→BUSY on a strobe, which captures the frame.
- BUSY→IDLE unconditionally, which emits the result.
- Any state→OFF whenever ready is low.

Top module: `kac_stereo_shell`

## Requirements
- R1: After reset `out_valid` is 0, both outputs are 0 and the gain factor is 0x4000 (0.5 in unsigned Q1.15).
- R2: At every clock edge that samples `host_ready` low, both outputs are cleared to 0 and `out_valid` is driven 0. No strobe is ever issued while the host is not ready.
- R3: The first `in_valid` strobe sampled while `host_ready` is high, counted since the last time ready was low, is an initialization frame. It produces no `out_valid`, and its samples never reach the outputs.
- R4: A frame strobed in cycle c gives `out_valid` high for exactly cycle c+2. A strobe that arrives in cycle c+1 (the busy cycle) is ignored.
- R5: When `sw_bypass` is 1 at the strobe, each output equals its input sample.
- R6: When `sw_bypass` is 0 and `sw_mute` is 1 at the strobe, both outputs are 0. Bypass wins over mute.
- R7: With both switches 0, each output is in·g/32768, truncated toward zero. Here g is bits [15:0] of the control word, read as unsigned Q1.15.
- R8: Scaled results above 8388607 give 8388607, and results below −8388608 give −8388608.
- R9: A one-cycle `gain_wr_en` loads `gain_wr_data`. Bits [31:16] have no effect. The new factor applies to frames strobed after the write edge.
- R10: While ready stays high, the outputs keep their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_ready | input | 1 | Host has finished its own setup |
| gain_wr_en | input | 1 | Control word write strobe |
| gain_wr_data | input | 32 | Raw control word, gain in bits [15:0] |
| sw_bypass | input | 1 | Bypass switch |
| sw_mute | input | 1 | Mute switch |
| in_valid | input | 1 | One-cycle frame strobe |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | One-cycle result strobe |
| out_left | output | 24 | Left output sample, signed |
| out_right | output | 24 | Right output sample, signed |

## Verification
Directed frames cover three groups of cases:
- Odd negative samples at the default factor, which separate truncation toward zero from flooring.
- Full-scale positive and negative samples with the factor near two, which exercise both saturation rails.
- A factor of exactly 1.0 written with garbage in the upper word, which shows the upper bits are ignored.

Random frames mix random samples, switch settings and factor rewrites against a bench model, so that the mode priority and the scaling are compared across the whole sample range. Two further sequences check the control gating. One sends back-to-back strobes to show the busy-cycle drop. The other drops and restores ready to show that outputs are cleared and that a new initialization frame is required.

// File: rtl/kac_pkg.sv
package kac_pkg;
    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_PRIME,
        ST_IDLE,
        ST_BUSY
    } kac_state_e;

    typedef enum logic [1:0] {
        MODE_PASS,
        MODE_MUTE,
        MODE_SCALE
    } kac_mode_e;
endpackage

// File: rtl/kac_gain_reg.sv
module kac_gain_reg #(
    parameter int CTRL_W     = 32,
    parameter int GAIN_W     = 16,
    parameter int GAIN_RESET = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [GAIN_W-1:0] gain_o
);
    logic [GAIN_W-1:0] gain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= GAIN_W'(GAIN_RESET);
        end else if (wr_en) begin
            gain_q <= wr_data[GAIN_W-1:0];
        end
    end

    assign gain_o = gain_q;
endmodule

// File: rtl/kac_scale_sat.sv
module kac_scale_sat #(
    parameter int SAMPLE_W = 24,
    parameter int GAIN_W   = 16
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [GAIN_W-1:0]   gain_i,
    output logic signed [SAMPLE_W-1:0] sample_o
);
    localparam int FRAC_W = GAIN_W - 1;
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] ONE_P  = PROD_W'(1);
    localparam logic signed [PROD_W-1:0] RND    = (ONE_P <<< FRAC_W) - ONE_P;
    localparam logic signed [PROD_W-1:0] MAXV   = (ONE_P <<< (SAMPLE_W-1)) - ONE_P;
    localparam logic signed [PROD_W-1:0] MINV   = -(ONE_P <<< (SAMPLE_W-1));

    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] biased;
    logic signed [PROD_W-1:0] shifted;

    always_comb begin
        s_ext   = PROD_W'(sample_i);
        g_ext   = PROD_W'({1'b0, gain_i});
        prod    = s_ext * g_ext;
        biased  = prod[PROD_W-1] ? (prod + RND) : prod;
        shifted = biased >>> FRAC_W;
        if (shifted > MAXV) begin
            sample_o = SAMPLE_W'(MAXV);
        end else if (shifted < MINV) begin
            sample_o = SAMPLE_W'(MINV);
        end else begin
            sample_o = SAMPLE_W'(shifted);
        end
    end
endmodule

// File: rtl/kac_ctrl_fsm.sv
module kac_ctrl_fsm
    import kac_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_ready,
    input  logic       in_valid,
    output logic       capture_en,
    output logic       emit_en,
    output logic       clear_out,
    output kac_state_e state_o
);
    kac_state_e state_q;
    kac_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   state_d = in_valid ? ST_IDLE : ST_PRIME;
            ST_PRIME: if (in_valid) state_d = ST_IDLE;
            ST_IDLE:  if (in_valid) state_d = ST_BUSY;
            ST_BUSY:  state_d = ST_IDLE;
            default:  state_d = ST_OFF;
        endcase
        if (!host_ready) begin
            state_d = ST_OFF;
        end
    end

    always_comb begin
        capture_en = 1'b0;
        emit_en    = 1'b0;
        clear_out  = !host_ready;
        unique case (state_q)
            ST_OFF, ST_PRIME: ;
            ST_IDLE:  capture_en = host_ready && in_valid;
            ST_BUSY:  emit_en    = host_ready;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/kac_stereo_shell.sv
module kac_stereo_shell
    import kac_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int CTRL_W     = 32,
    parameter int GAIN_W     = 16,
    parameter int GAIN_RESET = 16'h4000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_ready,
    input  logic                gain_wr_en,
    input  logic [CTRL_W-1:0]   gain_wr_data,
    input  logic                sw_bypass,
    input  logic                sw_mute,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right
);
    logic              capture_en;
    logic              emit_en;
    logic              clear_out;
    kac_state_e        fsm_state;
    logic [GAIN_W-1:0] gain_cur;

    logic signed [SAMPLE_W-1:0] in_smp  [NUM_CH];
    logic signed [SAMPLE_W-1:0] cap_smp [NUM_CH];
    logic signed [SAMPLE_W-1:0] scaled  [NUM_CH];
    logic signed [SAMPLE_W-1:0] result  [NUM_CH];
    logic signed [SAMPLE_W-1:0] out_smp [NUM_CH];
    kac_mode_e                  cap_mode;
    logic [GAIN_W-1:0]          cap_gain;
    logic                       out_valid_q;

    kac_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_ready (host_ready),
        .in_valid   (in_valid),
        .capture_en (capture_en),
        .emit_en    (emit_en),
        .clear_out  (clear_out),
        .state_o    (fsm_state)
    );

    kac_gain_reg #(
        .CTRL_W     (CTRL_W),
        .GAIN_W     (GAIN_W),
        .GAIN_RESET (GAIN_RESET)
    ) u_gain (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (gain_wr_en),
        .wr_data (gain_wr_data),
        .gain_o  (gain_cur)
    );

    assign in_smp[0] = in_left;
    assign in_smp[1] = in_right;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_mode <= MODE_MUTE;
            cap_gain <= '0;
        end else if (capture_en) begin
            cap_gain <= gain_cur;
            if (sw_bypass) begin
                cap_mode <= MODE_PASS;
            end else if (sw_mute) begin
                cap_mode <= MODE_MUTE;
            end else begin
                cap_mode <= MODE_SCALE;
            end
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cap_smp[ch] <= '0;
            end else if (capture_en) begin
                cap_smp[ch] <= in_smp[ch];
            end
        end

        kac_scale_sat #(
            .SAMPLE_W (SAMPLE_W),
            .GAIN_W   (GAIN_W)
        ) u_scale (
            .sample_i (cap_smp[ch]),
            .gain_i   (cap_gain),
            .sample_o (scaled[ch])
        );

        always_comb begin
            unique case (cap_mode)
                MODE_PASS:  result[ch] = cap_smp[ch];
                MODE_MUTE:  result[ch] = '0;
                MODE_SCALE: result[ch] = scaled[ch];
                default:    result[ch] = '0;
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n || clear_out) begin
                out_smp[ch] <= '0;
            end else if (emit_en) begin
                out_smp[ch] <= result[ch];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_out) begin
            out_valid_q <= 1'b0;
        end else begin
            out_valid_q <= emit_en;
        end
    end

    assign out_valid = out_valid_q;
    assign out_left  = out_smp[0];
    assign out_right = out_smp[1];
endmodule

// File: rtl/kac_stereo_shell_chk.sv
module kac_stereo_shell_chk #(
    parameter int SAMPLE_W = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                host_ready,
    input logic                sw_bypass,
    input logic                sw_mute,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_left,
    input logic [SAMPLE_W-1:0] in_right,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_left,
    input logic [SAMPLE_W-1:0] out_right
);
    AST_UNREADY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !host_ready |=> (!out_valid && out_left == '0 && out_right == '0)); // R2

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R4

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4

    AST_BYPASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(sw_bypass, 2)) |->
        (out_left == $past(in_left, 2) && out_right == $past(in_right, 2))); // R5

    AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(sw_bypass, 2) && $past(sw_mute, 2)) |->
        (out_left == '0 && out_right == '0)); // R6

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && $past(host_ready)) |->
        ($stable(out_left) && $stable(out_right))); // R10
endmodule

bind kac_stereo_shell kac_stereo_shell_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .sw_bypass  (sw_bypass),
    .sw_mute    (sw_mute),
    .in_valid   (in_valid),
    .in_left    (in_left),
    .in_right   (in_right),
    .out_valid  (out_valid),
    .out_left   (out_left),
    .out_right  (out_right)
);

// File: tb/kac_stereo_shell_test.sv
module kac_stereo_shell_test;
    localparam int SW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_ready = 1'b0;
    logic          gain_wr_en = 1'b0;
    logic [31:0]   gain_wr_data = '0;
    logic          sw_bypass = 1'b0;
    logic          sw_mute = 1'b0;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic          out_valid;
    logic [SW-1:0] out_left;
    logic [SW-1:0] out_right;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;
    logic [15:0] model_gain = 16'h4000;

    always #10 clk = ~clk;

    kac_stereo_shell uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_ready   (host_ready),
        .gain_wr_en   (gain_wr_en),
        .gain_wr_data (gain_wr_data),
        .sw_bypass    (sw_bypass),
        .sw_mute      (sw_mute),
        .in_valid     (in_valid),
        .in_left      (in_left),
        .in_right     (in_right),
        .out_valid    (out_valid),
        .out_left     (out_left),
        .out_right    (out_right)
    );

    function automatic longint sx(input logic [SW-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic longint expect_out(input longint x, input logic [15:0] g,
                                          input bit byp, input bit mute);
        longint p;
        longint q;
        if (byp) return x;
        if (mute) return 0;
        p = x * longint'(g);
        q = (p < 0) ? -((-p) >>> 15) : (p >>> 15);
        if (q > 8388607) q = 8388607;
        if (q < -8388608) q = -8388608;
        return q;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic write_gain(input logic [31:0] w);
        @(negedge clk);
        gain_wr_en   = 1'b1;
        gain_wr_data = w;
        @(negedge clk);
        gain_wr_en   = 1'b0;
        model_gain   = w[15:0];
    endtask

    // Full frame with result: strobe in cycle c, result in c+2, held in c+3.
    task automatic frame(input logic [SW-1:0] l, input logic [SW-1:0] r,
                         input bit byp, input bit mute, input string tag);
        longint el;
        longint er;
        el = expect_out(sx(l), model_gain, byp, mute);
        er = expect_out(sx(r), model_gain, byp, mute);
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = r; sw_bypass = byp; sw_mute = mute;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, {tag, " R4 early"}, out_valid, 0);
        @(negedge clk);
        check(out_valid == 1'b1, {tag, " R4 strobe"}, out_valid, 1);
        check(sx(out_left) == el && sx(out_right) == er, tag,
              sx(out_left) * 100000000 + sx(out_right), el * 100000000 + er);
        @(negedge clk);
        check(out_valid == 1'b0 && sx(out_left) == el, {tag, " R10 hold"},
              sx(out_left), el);
    endtask

    // Frame that must give no strobe and leave outputs at the given value.
    task automatic silent_frame(input logic [SW-1:0] l, input longint keep, input string tag);
        int seen;
        seen = 0;
        @(negedge clk);
        in_valid = 1'b1; in_left = l; in_right = l; sw_bypass = 1'b1; sw_mute = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (out_valid) seen++;
            @(negedge clk);
        end
        check(seen == 0 && sx(out_left) == keep, tag, seen * 1000 + sx(out_left), keep);
        sw_bypass = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 reset outputs",
              sx(out_left), 0);

        // R2 frames while host not ready
        silent_frame(24'd1234, 0, "R2 not ready");

        // R3 init frame
        @(negedge clk); host_ready = 1'b1;
        silent_frame(24'h123456, 0, "R3 init frame");

        // R1 default gain half, R7 truncation toward zero
        frame(24'd1000, -24'sd1001, 1'b0, 1'b0, "R1 R7 default half");
        frame(-24'sd3, 24'd3, 1'b0, 1'b0, "R7 trunc small");
        // R5 bypass, R6 priority and mute
        frame(24'h7FFFFF, 24'h800000, 1'b1, 1'b0, "R5 bypass");
        frame(24'd777, -24'sd555, 1'b1, 1'b1, "R6 bypass over mute");
        frame(24'd777, -24'sd555, 1'b0, 1'b1, "R6 mute");

        // R8 saturation with gain near two
        write_gain(32'hFFFF_FFFF);
        frame(24'h7FFFFF, 24'h800000, 1'b0, 1'b0, "R8 saturate");
        frame(24'h400000, 24'hC00000, 1'b0, 1'b0, "R8 edge");
        // R9 upper bits ignored: unity gain
        write_gain(32'hABCD_8000);
        frame(24'h7FFFFF, 24'h800001, 1'b0, 1'b0, "R9 unity upper ignored");

        // R4 second strobe in busy cycle dropped
        begin
            int seen;
            longint el;
            el = expect_out(sx(24'd4000), model_gain, 1'b0, 1'b0);
            seen = 0;
            @(negedge clk);
            in_valid = 1'b1; in_left = 24'd4000; in_right = 24'd4000; sw_bypass = 0; sw_mute = 0;
            @(negedge clk);
            in_left = 24'd9; in_right = 24'd9;
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b1 && sx(out_left) == el, "R4 busy first", sx(out_left), el);
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check(seen == 0, "R4 busy strobe ignored", seen, 0);
        end

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [SW-1:0] l;
            logic [SW-1:0] r;
            int m;
            if ($urandom_range(0, 9) == 0) write_gain($urandom());
            l = SW'($urandom());
            r = SW'($urandom());
            m = $urandom_range(0, 5);
            frame(l, r, m == 0, m == 1 || m == 0, "R5 R6 R7 random");
        end

        // R2 ready drop clears, R3 re-init required
        @(negedge clk); host_ready = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R2 ready drop clears",
              sx(out_left), 0);
        silent_frame(24'd55, 0, "R2 frame while low");
        @(negedge clk); host_ready = 1'b1;
        silent_frame(24'd66, 0, "R3 re-init frame");
        write_gain(32'h0000_4000);
        frame(-24'sd7, 24'd7, 1'b0, 1'b0, "R7 after re-init");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule